// File: doc/BRIEF.md
# Configurable Legacy Interrupt Router

This block sits between a set of legacy peripherals and an eight-input interrupt controller. Nine request inputs come in: two serial ports, a parallel port, a floppy controller, an IDE channel and four shared PCI-style lines (A to D). Each of them is steered onto one of the controller's numbered request lines. The choice is made by a 4-bit selector for each source, and the selectors are packed into configuration dwords. A trigger bitmap labels each output line as level- or edge-sensitive, and that label goes out next to the requests. A device-enable byte can block any of the five on-board peripherals.

Software programs the block through a 32-bit write port. The port takes a byte address and accepts only dword-aligned writes. More than one enabled source may pick the same line, and their requests are then ORed together. The merged request vector is registered, so the controller sees glitch-free inputs one clock after a source changes.

Top module: `lir_router`

## Requirements
- R1: After reset every selector, the enable byte and the trigger bitmap are zero, so `irq_req` and `irq_level` read 0.
- R2: Bits 31:24 of the dword written at offset 0x64 are the trigger bitmap. Bit n drives `irq_level[n]`, and a 1 there means level-sensitive while a 0 means edge-sensitive.
- R3: In the dword at offset 0x68, bits 11:8 select the line for serial port 1 and bits 15:12 select the line for serial port 2.
- R4: In the dword at offset 0x68, bits 19:16 select the line for the parallel port and bits 23:20 select the line for the floppy controller.
- R5: In the dword at offset 0x68, bits 27:24 select the line for the IDE channel. Bits 31:28 are reserved and have no effect on any output.
- R6: In the dword at offset 0x6C, bits 3:0, 7:4, 11:8 and 15:12 select the lines for shared lines A, B, C and D, in that order.
- R7: A selector value of 0, or of 8 or more, leaves its source unrouted, and line 0 is never asserted.
- R8: When several routed and enabled sources select the same line, that line is the OR of their requests.
- R9: Bits 23:16 of the dword at offset 0x58 form the enable byte. Bit 7 enables the floppy controller, bit 6 serial 1, bit 5 IDE, bit 4 serial 2 and bit 2 the parallel port, and a cleared bit blocks that source. The shared lines A to D are never gated.
- R10: A write is ignored when its address has bits 1:0 nonzero or names an offset other than 0x58, 0x64, 0x68 or 0x6C.
- R11: `irq_req` reflects `src_req` and the configuration sampled at the previous rising clock edge, with one register of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Byte address of the configuration write |
| cfg_wdata | input | 32 | Configuration write data |
| src_req | input | 9 | Requests: [0] serial 1, [1] serial 2, [2] parallel, [3] floppy, [4] IDE, [5..8] shared A..D |
| irq_req | output | 8 | Merged request per controller line |
| irq_level | output | 8 | Trigger type per line, 1 = level |

## Verification
The case that is hardest to reach is the one where sources of different kinds share a line while their gating differs. One example is a gated serial port and an ungated shared line that both land on the same line after the enable byte is cleared. Another is an out-of-range selector sitting next to a valid one inside the same byte. The stimulus first loads every routing dword, then rewrites the enable byte and the shared-line dword between request patterns. For each pattern it checks the merged vector, so the OR, the gating and the range check are all seen acting on a single line.

// File: rtl/lir_pkg.sv
package lir_pkg;

  // Source indices on src_req
  localparam int unsigned SRC_SER1 = 0;
  localparam int unsigned SRC_SER2 = 1;
  localparam int unsigned SRC_PAR  = 2;
  localparam int unsigned SRC_FLP  = 3;
  localparam int unsigned SRC_IDE  = 4;
  localparam int unsigned SRC_SHA  = 5;
  localparam int unsigned SRC_SHB  = 6;
  localparam int unsigned SRC_SHC  = 7;
  localparam int unsigned SRC_SHD  = 8;
  localparam int unsigned NUM_SRC  = 9;

  // Dword offsets of the configuration space
  localparam logic [7:0] OFS_ENABLE = 8'h58;
  localparam logic [7:0] OFS_TRIG   = 8'h64;
  localparam logic [7:0] OFS_ROUTE  = 8'h68;
  localparam logic [7:0] OFS_SHARED = 8'h6C;

  // Enable byte bit positions (inside bits 23:16 of the enable dword)
  localparam int unsigned EN_BYTE_LSB = 16;
  localparam int unsigned EN_FLP  = 7;
  localparam int unsigned EN_SER1 = 6;
  localparam int unsigned EN_IDE  = 5;
  localparam int unsigned EN_SER2 = 4;
  localparam int unsigned EN_PAR  = 2;

  // Trigger bitmap position in its dword
  localparam int unsigned TRIG_LSB = 24;

  // Held enable flags for the gated peripherals
  typedef struct packed {
    logic flp;
    logic ser1;
    logic ide;
    logic ser2;
    logic par;
  } dev_en_t;

endpackage

// File: rtl/lir_cfg_regs.sv
module lir_cfg_regs
  import lir_pkg::*;
#(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned SEL_W     = 4,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wdata,
  output dev_en_t                    en_q,
  output logic [NUM_LINES-1:0]       trig_q,
  output logic [NUM_SRC*SEL_W-1:0]   sel_q
);

  localparam int unsigned SEL_BITS = NUM_SRC * SEL_W;

  logic                  aligned;
  logic                  hit_en, hit_trig, hit_route, hit_shared;
  dev_en_t               en_d;
  logic [NUM_LINES-1:0]  trig_d;
  logic [SEL_BITS-1:0]   sel_d;

  // Address decode: only aligned dwords at known offsets are accepted
  always_comb begin
    aligned    = (addr[1:0] == 2'b00);
    hit_en     = we && aligned && (addr == ADDR_W'(OFS_ENABLE));
    hit_trig   = we && aligned && (addr == ADDR_W'(OFS_TRIG));
    hit_route  = we && aligned && (addr == ADDR_W'(OFS_ROUTE));
    hit_shared = we && aligned && (addr == ADDR_W'(OFS_SHARED));
  end

  // Next-state
  always_comb begin
    en_d   = en_q;
    trig_d = trig_q;
    sel_d  = sel_q;
    if (hit_en) begin
      en_d.flp  = wdata[EN_BYTE_LSB + EN_FLP];
      en_d.ser1 = wdata[EN_BYTE_LSB + EN_SER1];
      en_d.ide  = wdata[EN_BYTE_LSB + EN_IDE];
      en_d.ser2 = wdata[EN_BYTE_LSB + EN_SER2];
      en_d.par  = wdata[EN_BYTE_LSB + EN_PAR];
    end
    if (hit_trig) begin
      trig_d = wdata[TRIG_LSB +: NUM_LINES];
    end
    if (hit_route) begin
      sel_d[SRC_SER1*SEL_W +: SEL_W] = wdata[8  +: SEL_W];
      sel_d[SRC_SER2*SEL_W +: SEL_W] = wdata[12 +: SEL_W];
      sel_d[SRC_PAR *SEL_W +: SEL_W] = wdata[16 +: SEL_W];
      sel_d[SRC_FLP *SEL_W +: SEL_W] = wdata[20 +: SEL_W];
      sel_d[SRC_IDE *SEL_W +: SEL_W] = wdata[24 +: SEL_W];
    end
    if (hit_shared) begin
      sel_d[SRC_SHA*SEL_W +: SEL_W] = wdata[0  +: SEL_W];
      sel_d[SRC_SHB*SEL_W +: SEL_W] = wdata[4  +: SEL_W];
      sel_d[SRC_SHC*SEL_W +: SEL_W] = wdata[8  +: SEL_W];
      sel_d[SRC_SHD*SEL_W +: SEL_W] = wdata[12 +: SEL_W];
    end
  end

  // Register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      trig_q <= '0;
      sel_q  <= '0;
    end else if (we) begin
      en_q   <= en_d;
      trig_q <= trig_d;
      sel_q  <= sel_d;
    end
  end

endmodule

// File: rtl/lir_src_decode.sv
module lir_src_decode #(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned SEL_W     = 4
) (
  input  logic                 req,
  input  logic                 gate,
  input  logic [SEL_W-1:0]     sel,
  output logic [NUM_LINES-1:0] line_vec
);

  // Line 0 is the "unrouted" code; values at or beyond NUM_LINES match nothing.
  always_comb begin
    line_vec = '0;
    for (int l = 1; l < NUM_LINES; l++) begin
      line_vec[l] = req && gate && (sel == SEL_W'(l));
    end
  end

endmodule

// File: rtl/lir_line_merge.sv
module lir_line_merge #(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned NUM_IN    = 9
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_IN*NUM_LINES-1:0]   src_vecs,
  output logic [NUM_LINES-1:0]          irq_q
);

  logic [NUM_LINES-1:0] irq_d;

  always_comb begin
    irq_d = '0;
    for (int s = 0; s < NUM_IN; s++) begin
      irq_d = irq_d | src_vecs[s*NUM_LINES +: NUM_LINES];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_d;
  end

endmodule

// File: rtl/lir_router.sv
module lir_router
  import lir_pkg::*;
#(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned SEL_W     = 4,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic [DATA_W-1:0]    cfg_wdata,
  input  logic [NUM_SRC-1:0]   src_req,
  output logic [NUM_LINES-1:0] irq_req,
  output logic [NUM_LINES-1:0] irq_level
);

  dev_en_t                        en_q;
  logic [NUM_LINES-1:0]           trig_q;
  logic [NUM_SRC*SEL_W-1:0]       sel_q;
  logic [NUM_SRC-1:0]             gate;
  logic [NUM_SRC*NUM_LINES-1:0]   src_vecs;

  lir_cfg_regs #(
    .NUM_LINES (NUM_LINES),
    .SEL_W     (SEL_W),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (cfg_we),
    .addr   (cfg_addr),
    .wdata  (cfg_wdata),
    .en_q   (en_q),
    .trig_q (trig_q),
    .sel_q  (sel_q)
  );

  // Shared lines stay ungated; peripherals follow their enable flag
  always_comb begin
    gate           = '1;
    gate[SRC_SER1] = en_q.ser1;
    gate[SRC_SER2] = en_q.ser2;
    gate[SRC_PAR]  = en_q.par;
    gate[SRC_FLP]  = en_q.flp;
    gate[SRC_IDE]  = en_q.ide;
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    lir_src_decode #(
      .NUM_LINES (NUM_LINES),
      .SEL_W     (SEL_W)
    ) u_dec (
      .req      (src_req[s]),
      .gate     (gate[s]),
      .sel      (sel_q[s*SEL_W +: SEL_W]),
      .line_vec (src_vecs[s*NUM_LINES +: NUM_LINES])
    );
  end

  lir_line_merge #(
    .NUM_LINES (NUM_LINES),
    .NUM_IN    (NUM_SRC)
  ) u_merge (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_vecs (src_vecs),
    .irq_q    (irq_req)
  );

  assign irq_level = trig_q;

endmodule

// File: rtl/lir_router_chk.sv
module lir_router_chk
  import lir_pkg::*;
#(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned ADDR_W    = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cfg_we,
  input logic [ADDR_W-1:0]    cfg_addr,
  input logic [NUM_SRC-1:0]   src_req,
  input logic [NUM_LINES-1:0] irq_req,
  input logic [NUM_LINES-1:0] irq_level
);

  AST_LINE0_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req[0]); // R7

  AST_IDLE_SOURCES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(src_req) == '0) |-> (irq_req == '0)); // R11

  AST_TRIG_HELD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_we) |-> $stable(irq_level)); // R2

  AST_MISALIGNED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_we && (cfg_addr[1:0] != 2'b00)) |-> $stable(irq_level)); // R10

endmodule

bind lir_router lir_router_chk #(
  .NUM_LINES (NUM_LINES),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_addr  (cfg_addr),
  .src_req   (src_req),
  .irq_req   (irq_req),
  .irq_level (irq_level)
);

// File: tb/tb_lir_router.sv
module tb_lir_router;

  localparam int unsigned NL = 8;
  localparam int unsigned NS = 9;

  // src_req bit order: 0 ser1, 1 ser2, 2 par, 3 flp, 4 ide, 5..8 shared A..D
  localparam logic [NS-1:0] S_SER1 = 9'h001;
  localparam logic [NS-1:0] S_SER2 = 9'h002;
  localparam logic [NS-1:0] S_PAR  = 9'h004;
  localparam logic [NS-1:0] S_FLP  = 9'h008;
  localparam logic [NS-1:0] S_IDE  = 9'h010;
  localparam logic [NS-1:0] S_SHA  = 9'h020;
  localparam logic [NS-1:0] S_SHB  = 9'h040;
  localparam logic [NS-1:0] S_SHC  = 9'h080;
  localparam logic [NS-1:0] S_SHD  = 9'h100;

  logic          clk;
  logic          rst_n;
  logic          cfg_we;
  logic [7:0]    cfg_addr;
  logic [31:0]   cfg_wdata;
  logic [NS-1:0] src_req;
  logic [NL-1:0] irq_req;
  logic [NL-1:0] irq_level;

  typedef struct {
    logic [NL-1:0] req;
    logic [NL-1:0] lvl;
    string         tag;
  } exp_t;

  exp_t sb_q[$];
  int   n_vec;
  int   n_bad;
  bit   all_done;

  lir_router dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .src_req   (src_req),
    .irq_req   (irq_req),
    .irq_level (irq_level)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Monitor: pops one expectation per falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_vec++;
        if (irq_req !== e.req || irq_level !== e.lvl) begin
          n_bad++;
          $display("FAIL %s: req=%h lvl=%h expected req=%h lvl=%h",
                   e.tag, irq_req, irq_level, e.req, e.lvl);
        end
      end
    end
  end

  task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_addr  = a;
    cfg_wdata = d;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  // Drive a request pattern, wait the given edges, then queue the expectation
  task automatic drive(input logic [NS-1:0] s, input int edges,
                       input logic [NL-1:0] er, input logic [NL-1:0] el,
                       input string tag);
    exp_t e;
    @(negedge clk);
    src_req = s;
    repeat (edges) @(posedge clk);
    e.req = er;
    e.lvl = el;
    e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
  endtask

  initial begin
    n_vec = 0; n_bad = 0; all_done = 0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; src_req = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    drive(9'h000, 2, 8'h00, 8'h00, "R1 reset state");
    drive(S_SER1 | S_SHD, 2, 8'h00, 8'h00, "R1 nothing routed after reset");

    cfg_write(8'h64, 32'h8200_0000);
    drive(9'h000, 2, 8'h00, 8'h82, "R2 trigger bitmap lines 1 and 7 level");

    cfg_write(8'h68, 32'h0765_4300);
    drive(S_SER1, 2, 8'h00, 8'h82, "R9 serial 1 blocked while disabled");

    cfg_write(8'h58, 32'h00F4_0000);
    drive(S_SER1, 2, 8'h08, 8'h82, "R3 serial 1 on line 3");
    drive(S_SER2, 2, 8'h10, 8'h82, "R3 serial 2 on line 4");
    drive(S_PAR,  2, 8'h20, 8'h82, "R4 parallel on line 5");
    drive(S_FLP,  2, 8'h40, 8'h82, "R4 floppy on line 6");
    drive(S_IDE,  2, 8'h80, 8'h82, "R5 IDE on line 7");

    cfg_write(8'h6C, 32'h0000_1000);
    drive(S_SHD, 2, 8'h02, 8'h82, "R6 shared D on line 1");
    drive(S_SHA, 2, 8'h00, 8'h82, "R7 zero selector leaves shared A unrouted");

    // A=9, B=3, C=F, D=1
    cfg_write(8'h6C, 32'h0000_1F39);
    drive(S_SHA, 2, 8'h00, 8'h82, "R7 selector 9 ignored");
    drive(S_SHC, 2, 8'h00, 8'h82, "R7 selector F ignored");
    drive(S_SHB, 2, 8'h08, 8'h82, "R6 shared B on line 3");
    drive(S_SHB | S_SER1, 2, 8'h08, 8'h82, "R8 two sources share line 3");
    drive(S_SHB | S_SHD | S_SER2, 2, 8'h1A, 8'h82, "R8 merge of three lines");

    cfg_write(8'h68, 32'h5765_4300);
    drive(S_IDE | S_SER1, 2, 8'h88, 8'h82, "R5 reserved nibble has no effect");

    cfg_write(8'h65, 32'hFF00_0000);
    drive(9'h000, 2, 8'h00, 8'h82, "R10 misaligned write ignored");
    cfg_write(8'h60, 32'hFFFF_FFFF);
    drive(S_SER1, 2, 8'h08, 8'h82, "R10 unknown offset write ignored");

    cfg_write(8'h58, 32'h0000_0000);
    drive(9'h01F | S_SHB | S_SHD, 2, 8'h0A, 8'h82, "R9 shared lines ungated, peripherals blocked");
    cfg_write(8'h58, 32'h0040_0000);
    drive(S_SER1 | S_SER2, 2, 8'h08, 8'h82, "R9 only serial 1 enabled");

    drive(9'h000, 2, 8'h00, 8'h82, "R11 idle");
    drive(S_SER1, 1, 8'h08, 8'h82, "R11 one-cycle latency");

    cfg_write(8'h64, 32'h0000_0000);
    drive(9'h000, 2, 8'h00, 8'h00, "R2 bitmap cleared to all edge");

    repeat (3) @(negedge clk);
    all_done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!all_done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule